// File: doc/BRIEF.md
# Paged Address Translator with Associative Entry File

This block turns a logical address into a physical address for a paged memory system. The logical address splits into a page number (high bits) and an offset (low bits). The page number is first checked against a programmable highest-legal-page register. If the page number is out of range, the block traps and does no translation.

A legal page number goes to a small fully associative file of recent translations, and every entry is compared at once. On a hit, the stored frame number is joined to the offset. On a miss, the block reads one page-table entry from memory at the programmed table base plus the page number. It checks that entry's validity and permission bits and loads it into the file. The file uses the replacement order described in R8.

Software programs the table base and the page limit through two write strobes. Requests come one at a time through a valid/ready handshake. Each request gets exactly one response pulse, carrying either a physical address or a trap with a cause code.

The controller has five states:
- `ST_IDLE`: ready for a request. It moves to `ST_LOOKUP` when a request is accepted.
- `ST_LOOKUP`: runs the limit check and the associative search. It goes to `ST_RESP` on a limit trap or a hit, and to `ST_FETCH` on a miss.
- `ST_FETCH`: issues the single table read, then always moves to `ST_WAIT`.
- `ST_WAIT`: holds until read data returns, then moves to `ST_RESP`.
- `ST_RESP`: drives the response for one cycle, then returns to `ST_IDLE`.

Top module: `pager_xlate`

## Requirements
- R1: The page number is `req_laddr[LADDR_W-1:OFF_W]` and the offset is `req_laddr[OFF_W-1:0]`. A successful translation returns `rsp_paddr = {frame, offset}`.
- R2: If the page number is greater than the limit register, the response has `rsp_trap=1` and `rsp_cause=1`. No memory read is issued and the entry file is not changed. A page number equal to the limit is legal.
- R3: All valid entries are compared with the page number in parallel, and at most one matches. A hit responds with no memory read, with `rsp_valid` high in the second cycle after the accepting edge.
- R4: On a miss, exactly one read is issued, for one cycle, at address `base + page`.
- R5: A page-table entry read from memory has this layout: bit `FRAME_W+1` is the valid flag, bit `FRAME_W` is write-permitted, and bits `FRAME_W-1:0` are the frame number.
- R6: A fetched entry whose valid flag is 0 gives a trap with `rsp_cause=2`. That entry is not loaded, so the next access to the same page reads memory again.
- R7: A write request to a page whose write-permitted bit is 0 gives a trap with `rsp_cause=3`. This applies on a hit and on a refill. A refill that traps this way still loads the entry.
- R8: Each hit or refill stamps the entry with a counter value that increases on every use. A refill goes to the lowest-numbered empty entry if one exists. Otherwise it replaces the entry with the smallest stamp.
- R9: A write to the base register invalidates all entries from the next cycle on. A walk that is in progress while the base changes does not load its entry.
- R10: After reset, `req_ready=1`, `rsp_valid=0` and `mem_rd_en=0`. The file is empty, and both the base and the limit registers are 0.
- R11: Only one request is in flight at a time. `req_ready` is low from the cycle after acceptance until the response cycle has passed, and `rsp_valid` is a single-cycle pulse.
- R12: A trapped response carries `rsp_paddr=0`. `rsp_cause=0` means no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | LADDR_W | Logical address |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address |
| rsp_trap | output | 1 | Response is a trap |
| rsp_cause | output | 2 | 0 none, 1 limit, 2 invalid entry, 3 write protect |
| mem_rd_en | output | 1 | Page-table read strobe |
| mem_rd_addr | output | MADDR_W | Page-table read address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | FRAME_W+2 | Page-table entry |
| cfg_base_we | input | 1 | Base register write |
| cfg_base_data | input | MADDR_W | New base value |
| cfg_limit_we | input | 1 | Limit register write |
| cfg_limit_data | input | LADDR_W-OFF_W | Highest legal page |

## Verification
The translator is exercised with several kinds of request:
- Repeated pages with changing offsets, which separate hits from misses by whether a table read occurs.
- Pages at and just above the limit, which confirm the boundary of the range check.
- Pages whose table entries are invalid or read-only, tried with both reads and writes. These show which trap code wins and whether the entry was kept.

A fill-then-reuse sequence over more than eight pages shows which entry each refill evicts, because an evicted page must be read again. Changing the base and revisiting a cached page shows that the flush took effect, because a new frame number comes back.

// File: rtl/pager_pkg.sv
package pager_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_LIMIT   = 2'd1,
        CAUSE_INVALID = 2'd2,
        CAUSE_PROTECT = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 8,
    parameter int PAGE_W  = 8,
    parameter int FRAME_W = 10,
    parameter int STAMP_W = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PAGE_W-1:0]          lookup_page,
    input  logic                       flush,
    input  logic                       fill_en,
    input  logic [IDX_W-1:0]           fill_idx,
    input  logic [PAGE_W-1:0]          fill_page,
    input  logic [FRAME_W-1:0]         fill_frame,
    input  logic                       fill_wr,
    input  logic                       touch_en,
    input  logic [IDX_W-1:0]           touch_idx,
    input  logic [STAMP_W-1:0]         stamp_now,
    output logic [ENTRIES-1:0]         hit_vec,
    output logic                       hit_any,
    output logic [IDX_W-1:0]           hit_idx,
    output logic [FRAME_W-1:0]         hit_frame,
    output logic                       hit_wr,
    output logic [ENTRIES-1:0]         valid_vec,
    output logic [ENTRIES*STAMP_W-1:0] stamps_flat
);
    logic               valid_q [ENTRIES];
    logic [PAGE_W-1:0]  page_q  [ENTRIES];
    logic [FRAME_W-1:0] frame_q [ENTRIES];
    logic               wr_q    [ENTRIES];
    logic [STAMP_W-1:0] stamp_q [ENTRIES];

    // Entry storage: flush wins over fill and touch in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                valid_q[e] <= 1'b0;
                page_q[e]  <= '0;
                frame_q[e] <= '0;
                wr_q[e]    <= 1'b0;
                stamp_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (flush) begin
                    valid_q[e] <= 1'b0;
                end else if (fill_en && fill_idx == IDX_W'(e)) begin
                    valid_q[e] <= 1'b1;
                    page_q[e]  <= fill_page;
                    frame_q[e] <= fill_frame;
                    wr_q[e]    <= fill_wr;
                    stamp_q[e] <= stamp_now;
                end else if (touch_en && touch_idx == IDX_W'(e)) begin
                    stamp_q[e] <= stamp_now;
                end
            end
        end
    end

    // Parallel comparators, one per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g]   = valid_q[g] && (page_q[g] == lookup_page);
        assign valid_vec[g] = valid_q[g];
        assign stamps_flat[g*STAMP_W +: STAMP_W] = stamp_q[g];
    end

    // OR-reduction mux: at most one entry matches.
    always_comb begin
        hit_frame = '0;
        hit_wr    = 1'b0;
        hit_idx   = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit_vec[e]) begin
                hit_frame = hit_frame | frame_q[e];
                hit_wr    = hit_wr | wr_q[e];
                hit_idx   = hit_idx | IDX_W'(e);
            end
        end
    end

    assign hit_any = |hit_vec;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8,
    parameter int STAMP_W = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]         valid_vec,
    input  logic [ENTRIES*STAMP_W-1:0] stamps_flat,
    output logic [IDX_W-1:0]           victim_idx
);
    logic               have_free;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   min_idx;
    logic [STAMP_W-1:0] min_val;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        min_idx   = '0;
        min_val   = stamps_flat[STAMP_W-1:0];
        for (int e = 0; e < ENTRIES; e++) begin
            if (!valid_vec[e] && !have_free) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(e);
            end
            if (stamps_flat[e*STAMP_W +: STAMP_W] < min_val) begin
                min_val = stamps_flat[e*STAMP_W +: STAMP_W];
                min_idx = IDX_W'(e);
            end
        end
        victim_idx = have_free ? free_idx : min_idx;
    end
endmodule

// File: rtl/tlb_walk_ctrl.sv
module tlb_walk_ctrl
    import pager_pkg::*;
#(
    parameter int LADDR_W  = 16,
    parameter int OFF_W    = 8,
    parameter int FRAME_W  = 10,
    parameter int MADDR_W  = 12,
    parameter int ENTRIES  = 8,
    localparam int PAGE_W  = LADDR_W - OFF_W,
    localparam int PADDR_W = FRAME_W + OFF_W,
    localparam int PTE_W   = FRAME_W + 2,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [LADDR_W-1:0] req_laddr,
    input  logic               req_write,
    input  logic [MADDR_W-1:0] base,
    input  logic [PAGE_W-1:0]  limit,
    input  logic               flush,
    input  logic               hit_any,
    input  logic [IDX_W-1:0]   hit_idx,
    input  logic [FRAME_W-1:0] hit_frame,
    input  logic               hit_wr,
    input  logic [IDX_W-1:0]   victim_idx,
    input  logic               mem_rd_valid,
    input  logic [PTE_W-1:0]   mem_rd_data,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [PADDR_W-1:0] rsp_paddr,
    output logic               rsp_trap,
    output logic [1:0]         rsp_cause,
    output logic               mem_rd_en,
    output logic [MADDR_W-1:0] mem_rd_addr,
    output logic [PAGE_W-1:0]  lookup_page,
    output logic               fill_en,
    output logic [IDX_W-1:0]   fill_idx,
    output logic [FRAME_W-1:0] fill_frame,
    output logic               fill_wr,
    output logic               touch_en,
    output logic [IDX_W-1:0]   touch_idx
);
    state_e               state_q, state_d;
    logic [LADDR_W-1:0]   laddr_q;
    logic                 write_q;
    logic                 stale_q;
    cause_e               cause_q;
    logic [PADDR_W-1:0]   paddr_q;

    logic [PAGE_W-1:0]    page;
    logic [OFF_W-1:0]     offset;
    logic                 over_limit;
    logic                 pte_v;
    logic                 pte_w;
    logic [FRAME_W-1:0]   pte_frame;

    assign page       = laddr_q[LADDR_W-1:OFF_W];
    assign offset     = laddr_q[OFF_W-1:0];
    assign over_limit = page > limit;
    assign pte_v      = mem_rd_data[FRAME_W+1];
    assign pte_w      = mem_rd_data[FRAME_W];
    assign pte_frame  = mem_rd_data[FRAME_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and entry-file control
    always_comb begin
        state_d  = state_q;
        touch_en = 1'b0;
        fill_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (over_limit) begin
                    state_d = ST_RESP;
                end else if (hit_any) begin
                    touch_en = 1'b1;
                    state_d  = ST_RESP;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    fill_en = pte_v && !stale_q;
                    state_d = ST_RESP;
                end
            end
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Request capture, walk staleness and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            laddr_q <= '0;
            write_q <= 1'b0;
            stale_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                laddr_q <= req_laddr;
                write_q <= req_write;
            end
            if (state_q == ST_LOOKUP) stale_q <= 1'b0;
            else if (flush)           stale_q <= 1'b1;

            if (state_q == ST_LOOKUP) begin
                if (over_limit) begin
                    cause_q <= CAUSE_LIMIT;
                    paddr_q <= '0;
                end else if (hit_any) begin
                    if (write_q && !hit_wr) begin
                        cause_q <= CAUSE_PROTECT;
                        paddr_q <= '0;
                    end else begin
                        cause_q <= CAUSE_NONE;
                        paddr_q <= {hit_frame, offset};
                    end
                end
            end else if (state_q == ST_WAIT && mem_rd_valid) begin
                if (!pte_v) begin
                    cause_q <= CAUSE_INVALID;
                    paddr_q <= '0;
                end else if (write_q && !pte_w) begin
                    cause_q <= CAUSE_PROTECT;
                    paddr_q <= '0;
                end else begin
                    cause_q <= CAUSE_NONE;
                    paddr_q <= {pte_frame, offset};
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_rd_en = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_LOOKUP: ;
            ST_FETCH:  mem_rd_en = 1'b1;
            ST_WAIT:   ;
            ST_RESP:   rsp_valid = 1'b1;
            default:   ;
        endcase
    end

    assign rsp_paddr   = paddr_q;
    assign rsp_cause   = cause_q;
    assign rsp_trap    = rsp_valid && (cause_q != CAUSE_NONE);
    assign mem_rd_addr = base + MADDR_W'(page);
    assign lookup_page = page;
    assign fill_idx    = victim_idx;
    assign fill_frame  = pte_frame;
    assign fill_wr     = pte_w;
    assign touch_idx   = hit_idx;
endmodule

// File: rtl/pager_xlate.sv
module pager_xlate #(
    parameter int LADDR_W  = 16,
    parameter int OFF_W    = 8,
    parameter int FRAME_W  = 10,
    parameter int MADDR_W  = 12,
    parameter int ENTRIES  = 8,
    parameter int STAMP_W  = 16,
    localparam int PAGE_W  = LADDR_W - OFF_W,
    localparam int PADDR_W = FRAME_W + OFF_W,
    localparam int PTE_W   = FRAME_W + 2,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [LADDR_W-1:0] req_laddr,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic [PADDR_W-1:0] rsp_paddr,
    output logic               rsp_trap,
    output logic [1:0]         rsp_cause,
    output logic               mem_rd_en,
    output logic [MADDR_W-1:0] mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [PTE_W-1:0]   mem_rd_data,
    input  logic               cfg_base_we,
    input  logic [MADDR_W-1:0] cfg_base_data,
    input  logic               cfg_limit_we,
    input  logic [PAGE_W-1:0]  cfg_limit_data
);
    logic [MADDR_W-1:0]         base_q;
    logic [PAGE_W-1:0]          limit_q;
    logic [STAMP_W-1:0]         stamp_cnt;

    logic [PAGE_W-1:0]          lookup_page;
    logic                       fill_en, fill_wr, touch_en;
    logic [IDX_W-1:0]           fill_idx, touch_idx, hit_idx, victim_idx;
    logic [FRAME_W-1:0]         fill_frame, hit_frame;
    logic                       hit_any, hit_wr;
    logic [ENTRIES-1:0]         hit_vec, valid_vec;
    logic [ENTRIES*STAMP_W-1:0] stamps_flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            limit_q   <= '0;
            stamp_cnt <= '0;
        end else begin
            if (cfg_base_we)  base_q  <= cfg_base_data;
            if (cfg_limit_we) limit_q <= cfg_limit_data;
            if (fill_en || touch_en) stamp_cnt <= stamp_cnt + 1'b1;
        end
    end

    tlb_walk_ctrl #(
        .LADDR_W(LADDR_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W),
        .MADDR_W(MADDR_W), .ENTRIES(ENTRIES)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_laddr(req_laddr), .req_write(req_write),
        .base(base_q), .limit(limit_q), .flush(cfg_base_we),
        .hit_any(hit_any), .hit_idx(hit_idx), .hit_frame(hit_frame), .hit_wr(hit_wr),
        .victim_idx(victim_idx),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .lookup_page(lookup_page),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_frame(fill_frame), .fill_wr(fill_wr),
        .touch_en(touch_en), .touch_idx(touch_idx)
    );

    tlb_cam #(
        .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .STAMP_W(STAMP_W)
    ) cam_i (
        .clk(clk), .rst_n(rst_n),
        .lookup_page(lookup_page), .flush(cfg_base_we),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_page(lookup_page),
        .fill_frame(fill_frame), .fill_wr(fill_wr),
        .touch_en(touch_en), .touch_idx(touch_idx), .stamp_now(stamp_cnt),
        .hit_vec(hit_vec), .hit_any(hit_any), .hit_idx(hit_idx),
        .hit_frame(hit_frame), .hit_wr(hit_wr),
        .valid_vec(valid_vec), .stamps_flat(stamps_flat)
    );

    tlb_victim #(
        .ENTRIES(ENTRIES), .STAMP_W(STAMP_W)
    ) victim_i (
        .valid_vec(valid_vec), .stamps_flat(stamps_flat), .victim_idx(victim_idx)
    );
endmodule

// File: rtl/pager_xlate_chk.sv
module pager_xlate_chk #(
    parameter int ENTRIES = 8,
    parameter int PADDR_W = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_trap,
    input logic [PADDR_W-1:0] rsp_paddr,
    input logic               mem_rd_en,
    input logic               cfg_base_we,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] valid_vec
);
    assert_hit_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_base_we |=> (valid_vec == '0));

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_no_read_in_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_rd_en);

    assert_trap_zero_paddr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap) |-> (rsp_paddr == '0));
endmodule

bind pager_xlate pager_xlate_chk #(.ENTRIES(ENTRIES), .PADDR_W(PADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_paddr(rsp_paddr),
    .mem_rd_en(mem_rd_en), .cfg_base_we(cfg_base_we),
    .hit_vec(hit_vec), .valid_vec(valid_vec)
);

// File: tb/pager_xlate_tb_top.sv
module pager_xlate_tb_top;
    localparam int LADDR_W = 16;
    localparam int OFF_W   = 8;
    localparam int FRAME_W = 10;
    localparam int MADDR_W = 12;
    localparam int NENT    = 8;
    localparam int PAGE_W  = LADDR_W - OFF_W;
    localparam int PADDR_W = FRAME_W + OFF_W;
    localparam int PTE_W   = FRAME_W + 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [LADDR_W-1:0] req_laddr = '0;
    logic               req_write = 1'b0;
    logic               rsp_valid;
    logic [PADDR_W-1:0] rsp_paddr;
    logic               rsp_trap;
    logic [1:0]         rsp_cause;
    logic               mem_rd_en;
    logic [MADDR_W-1:0] mem_rd_addr;
    logic               mem_rd_valid = 1'b0;
    logic [PTE_W-1:0]   mem_rd_data = '0;
    logic               cfg_base_we = 1'b0;
    logic [MADDR_W-1:0] cfg_base_data = '0;
    logic               cfg_limit_we = 1'b0;
    logic [PAGE_W-1:0]  cfg_limit_data = '0;

    always #5 clk = ~clk;

    pager_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .cfg_base_we(cfg_base_we), .cfg_base_data(cfg_base_data),
        .cfg_limit_we(cfg_limit_we), .cfg_limit_data(cfg_limit_data)
    );

    typedef struct {
        logic [PADDR_W-1:0] paddr;
        logic               trap;
        logic [1:0]         cause;
        logic               fetched;
        string              tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   rd_cnt   = 0;
    int   rd_seen  = 0;

    // Reference model of the entry file, built from R8 and R9.
    logic               mv [NENT];
    logic [PAGE_W-1:0]  mp [NENT];
    int                 ms [NENT];
    int                 mcnt = 0;
    logic [MADDR_W-1:0] base_m = '0;
    logic [PAGE_W-1:0]  limit_m = '0;

    // Table contents in memory. Layout per R5: {valid, write-permitted, frame}.
    function automatic logic [PTE_W-1:0] pte_of(input logic [MADDR_W-1:0] a);
        logic v, w;
        logic [FRAME_W-1:0] f;
        v = (a[2:0] != 3'd7);
        w = a[0];
        f = FRAME_W'(a * 3 + 5);
        return {v, w, f};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %s expected %s", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Memory responder: data arrives two falling edges after the strobe.
    logic               pend = 1'b0;
    logic [MADDR_W-1:0] hold = '0;
    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (pend) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = pte_of(hold);
            pend = 1'b0;
        end
        if (rst_n && mem_rd_en) begin
            pend = 1'b1;
            hold = mem_rd_addr;
            rd_cnt++;
        end
    end

    // Monitor: pops one expected item per response pulse.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected response", "pulse", "none");
            end else begin
                exp_t e;
                logic fetched;
                e = exp_q.pop_front();
                fetched = (rd_cnt != rd_seen);
                check(rsp_paddr == e.paddr, e.tag, "paddr",
                      $sformatf("%h", rsp_paddr), $sformatf("%h", e.paddr));
                check(rsp_trap == e.trap && rsp_cause == e.cause, e.tag, "trap/cause",
                      $sformatf("%0b/%0d", rsp_trap, rsp_cause),
                      $sformatf("%0b/%0d", e.trap, e.cause));
                check(fetched == e.fetched, e.tag, "table read occurred",
                      $sformatf("%0b", fetched), $sformatf("%0b", e.fetched));
            end
            rd_seen = rd_cnt;
        end
    end

    task automatic set_base(input logic [MADDR_W-1:0] v);
        @(negedge clk);
        cfg_base_we = 1'b1;
        cfg_base_data = v;
        @(negedge clk);
        cfg_base_we = 1'b0;
        base_m = v;
        for (int i = 0; i < NENT; i++) mv[i] = 1'b0;   // R9
    endtask

    task automatic set_limit(input logic [PAGE_W-1:0] v);
        @(negedge clk);
        cfg_limit_we = 1'b1;
        cfg_limit_data = v;
        @(negedge clk);
        cfg_limit_we = 1'b0;
        limit_m = v;
    endtask

    // Driver: predicts the response, queues it, then runs the handshake.
    task automatic xlate(input logic [LADDR_W-1:0] la, input logic wr, input string tag);
        exp_t e;
        logic [PAGE_W-1:0] pg;
        logic [OFF_W-1:0]  off;
        logic [PTE_W-1:0]  pte;
        int hit;
        pg  = la[LADDR_W-1:OFF_W];     // R1 split
        off = la[OFF_W-1:0];
        e.tag = tag;
        e.fetched = 1'b0;
        e.cause = 2'd0;
        hit = -1;
        if (pg > limit_m) begin
            e.cause = 2'd1;            // R2
        end else begin
            for (int i = 0; i < NENT; i++) if (mv[i] && mp[i] == pg) hit = i;
            pte = pte_of(base_m + MADDR_W'(pg));
            if (hit >= 0) begin
                ms[hit] = mcnt++;
            end else begin
                e.fetched = 1'b1;
                if (!pte[FRAME_W+1]) begin
                    e.cause = 2'd2;    // R6
                end else begin
                    int vic;
                    int mn;
                    vic = -1;
                    for (int i = 0; i < NENT; i++) if (!mv[i] && vic < 0) vic = i;
                    if (vic < 0) begin
                        vic = 0;
                        mn  = ms[0];
                        for (int i = 1; i < NENT; i++) if (ms[i] < mn) begin mn = ms[i]; vic = i; end
                    end
                    mv[vic] = 1'b1;    // R8
                    mp[vic] = pg;
                    ms[vic] = mcnt++;
                end
            end
            if (e.cause == 2'd0 && wr && !pte[FRAME_W]) e.cause = 2'd3;   // R7
        end
        e.trap  = (e.cause != 2'd0);
        e.paddr = e.trap ? '0 : {pte[FRAME_W-1:0], off};   // R12 zero on trap
        exp_q.push_back(e);

        @(negedge clk);
        req_valid = 1'b1;
        req_laddr = la;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R11", "ready while busy",
              $sformatf("%0b", req_ready), "0");
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", "run completed", "timeout", "finish");
        summary();
    end

    initial begin
        for (int i = 0; i < NENT; i++) begin mv[i] = 1'b0; mp[i] = '0; ms[i] = 0; end
        repeat (3) @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10", "req_ready", $sformatf("%0b", req_ready), "1");
        check(rsp_valid == 1'b0, "R10", "rsp_valid", $sformatf("%0b", rsp_valid), "0");
        check(mem_rd_en == 1'b0, "R10", "mem_rd_en", $sformatf("%0b", mem_rd_en), "0");
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R10", "idle after release",
              $sformatf("%0b%0b", req_ready, rsp_valid), "10");

        // R10: base 0 and limit 0 after reset
        xlate(16'h0012, 1'b0, "R10");
        xlate(16'h0123, 1'b0, "R10");

        set_limit(8'h3F);
        set_base(12'h100);
        xlate(16'h0134, 1'b0, "R4");    // miss, read at base+page
        xlate(16'h01FF, 1'b0, "R3");    // hit, new offset
        xlate(16'h0100, 1'b1, "R1");    // hit, write allowed (a=0x101)
        xlate(16'h05C3, 1'b0, "R5");    // miss, frame from table layout
        xlate(16'h05C4, 1'b1, "R5");    // hit, write allowed (a=0x105)
        xlate(16'h4000, 1'b0, "R2");    // one above limit
        xlate(16'hFF01, 1'b1, "R2");    // far above limit
        xlate(16'h3FAA, 1'b0, "R2");    // equal to limit, legal (entry invalid)
        xlate(16'h0705, 1'b0, "R6");    // invalid entry
        xlate(16'h0706, 1'b0, "R6");    // read again, not cached
        xlate(16'h0211, 1'b1, "R7");    // refill, read-only, write traps
        xlate(16'h0222, 1'b1, "R7");    // hit, still traps
        xlate(16'h0233, 1'b0, "R7");    // read of read-only page succeeds

        // R8: fill and evict
        set_base(12'h200);
        xlate(16'h0101, 1'b0, "R8");
        xlate(16'h0202, 1'b0, "R8");
        xlate(16'h0303, 1'b0, "R8");
        xlate(16'h0404, 1'b0, "R8");
        xlate(16'h0505, 1'b0, "R8");
        xlate(16'h0606, 1'b0, "R8");
        xlate(16'h0808, 1'b0, "R8");
        xlate(16'h0909, 1'b0, "R8");
        xlate(16'h0111, 1'b0, "R8");    // hit refreshes page 1
        xlate(16'h0A0A, 1'b0, "R8");    // evicts page 2
        xlate(16'h0222, 1'b0, "R8");    // page 2 read again, evicts page 3
        xlate(16'h0112, 1'b0, "R8");    // page 1 still present
        xlate(16'h0333, 1'b0, "R8");    // page 3 read again
        xlate(16'h0A0B, 1'b0, "R8");    // page 10 still present

        // R9: new base drops cached pages
        set_base(12'h300);
        xlate(16'h0144, 1'b0, "R9");
        xlate(16'h0A55, 1'b0, "R9");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R11", "all responses seen",
              $sformatf("%0d", exp_q.size()), "0");
        summary();
    end
endmodule